// File: doc/BRIEF.md
# Critical-Word-First Cache Line Filler

The block runs the refill of one cache line after a read miss. When a miss is accepted it sends a single burst request to the next memory level. The request carries the line number and the word the burst starts at. As words return, one per cycle whenever memory marks its data valid, the block writes each one into the line storage at the right word position. The word the processor missed on is passed straight through to the processor in the cycle it arrives, and the processor stall drops in that same cycle. The remaining words keep filling afterwards.

A static mode input selects the burst order. In wrap-around order the burst starts at the missed word and continues upward modulo the line length. In natural order the burst starts at word 0 and the missed word is forwarded early when its turn comes.

A per-word valid mask covers the line being filled. A later read to that line stalls only until the specific word it needs has been written. Reads to other lines are never stalled. Only one fill is outstanding at a time, and a new miss is held off by a low ready until the current fill completes.

Top module: `cwf_line_fill`

## Requirements
- R1: While reset is held, and in the first idle cycle after reset, miss_ready is 1 and cpu_stall, mem_req, fill_we, fwd_valid, fill_done and rd_stall are all 0.
- R2: While idle, a cycle with miss_valid high accepts the miss. In that same cycle, mem_req is 1, mem_req_line equals miss_line and miss_ready is 1. From the next cycle, miss_ready is 0 until the fill completes.
- R3: With mode_wrap = 1, mem_req_word equals miss_word. The k-th returned word (k = 0..15) is written with fill_word = (miss_word + k) mod 16, and fill_data equals mem_data.
- R4: With mode_wrap = 0, mem_req_word is 0 and the k-th returned word is written with fill_word = k.
- R5: In the cycle the missed word arrives, fwd_valid is 1, fwd_data equals mem_data, and cpu_stall is 0. In every earlier cycle of the fill cpu_stall is 1, and from that cycle on it stays 0.
- R6: Every cycle with mem_valid high during a fill writes a word (fill_we = 1), including the cycles after the processor has been released. Cycles without mem_valid write nothing.
- R7: A read (rd_req = 1) to the line being filled has rd_stall = 1 exactly when its word was not written in an earlier cycle of this fill. A read to any other line, or any read while idle, has rd_stall = 0.
- R8: While a fill is in progress, miss_valid is not accepted: miss_ready is 0 and mem_req stays 0.
- R9: fill_done is 1 in the cycle of the 16th returned word, and miss_ready is 1 again in the next cycle.
- R10: mem_valid while idle is ignored: fill_we, fwd_valid and fill_done stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mode_wrap | input | 1 | 1: wrap-around order from the missed word; 0: natural order from word 0 |
| miss_valid | input | 1 | Read miss presented |
| miss_line | input | 8 | Line number of the miss |
| miss_word | input | 4 | Missed word within the line |
| miss_ready | output | 1 | No fill in progress; a miss can be accepted |
| cpu_stall | output | 1 | Processor is waiting for its missed word |
| fwd_valid | output | 1 | Missed word being forwarded this cycle |
| fwd_data | output | 32 | Forwarded word |
| mem_req | output | 1 | Burst request to memory (one cycle) |
| mem_req_line | output | 8 | Line number requested |
| mem_req_word | output | 4 | First word of the burst |
| mem_valid | input | 1 | Memory returns a word this cycle |
| mem_data | input | 32 | Returned word |
| fill_we | output | 1 | Write a word into the line storage |
| fill_word | output | 4 | Word position being written |
| fill_data | output | 32 | Word being written |
| fill_done | output | 1 | Last word of the line is written this cycle |
| rd_req | input | 1 | Processor read probe |
| rd_line | input | 8 | Line of the read |
| rd_word | input | 4 | Word of the read |
| rd_stall | output | 1 | Read must wait for its word |

## Verification
The outputs tied to a returning word (fill_we, fill_word, fill_data, fwd_valid, fwd_data, fill_done, and the drop of cpu_stall) are due in the same cycle as mem_valid. The request outputs are due in the same cycle as the accepted miss. miss_ready falls one cycle after acceptance and rises one cycle after the last word. rd_stall for a word clears one cycle after that word is written. The bench drives inputs on the falling edge, samples these combinational outputs shortly afterwards, and checks them against a model that tracks the expected word index, the words already written and whether the forward has happened. It does this under random gaps between returned words, in both orders, and with the missed word placed at the first, a middle and the last position.

// File: rtl/cwf_line_fill.sv
module cwf_line_fill #(
  parameter int WORDS = 16,
  parameter int DW    = 32,
  parameter int LW    = 8,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wrap,
  input  logic          miss_valid,
  input  logic [LW-1:0] miss_line,
  input  logic [IW-1:0] miss_word,
  output logic          miss_ready,
  output logic          cpu_stall,
  output logic          fwd_valid,
  output logic [DW-1:0] fwd_data,
  output logic          mem_req,
  output logic [LW-1:0] mem_req_line,
  output logic [IW-1:0] mem_req_word,
  input  logic          mem_valid,
  input  logic [DW-1:0] mem_data,
  output logic          fill_we,
  output logic [IW-1:0] fill_word,
  output logic [DW-1:0] fill_data,
  output logic          fill_done,
  input  logic          rd_req,
  input  logic [LW-1:0] rd_line,
  input  logic [IW-1:0] rd_word,
  output logic          rd_stall
);

  logic             busy, wrap_r, crit_done;
  logic [LW-1:0]    line_r;
  logic [IW-1:0]    crit_r, cnt, idx;
  logic [WORDS-1:0] vmask;
  logic             last;

  assign idx          = wrap_r ? IW'(crit_r + cnt) : cnt;
  assign last         = (cnt == IW'(WORDS - 1));

  assign miss_ready   = !busy;
  assign mem_req      = miss_valid && !busy;
  assign mem_req_line = miss_line;
  assign mem_req_word = mode_wrap ? miss_word : '0;

  assign fill_we      = busy && mem_valid;
  assign fill_word    = idx;
  assign fill_data    = mem_data;
  assign fill_done    = fill_we && last;

  assign fwd_valid    = fill_we && !crit_done && (idx == crit_r);
  assign fwd_data     = mem_data;
  assign cpu_stall    = busy && !crit_done && !fwd_valid;

  assign rd_stall     = rd_req && busy && (rd_line == line_r) && !vmask[rd_word];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      wrap_r    <= 1'b0;
      crit_done <= 1'b0;
      line_r    <= '0;
      crit_r    <= '0;
      cnt       <= '0;
      vmask     <= '0;
    end else if (mem_req) begin
      busy      <= 1'b1;
      wrap_r    <= mode_wrap;
      crit_done <= 1'b0;
      line_r    <= miss_line;
      crit_r    <= miss_word;
      cnt       <= '0;
      vmask     <= '0;
    end else if (fill_we) begin
      cnt        <= cnt + 1'b1;
      vmask[idx] <= 1'b1;
      if (fwd_valid) crit_done <= 1'b1;
      if (last)      busy      <= 1'b0;
    end
  end

  AST_NO_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_ready |-> !mem_req); // R8
  AST_FWD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> !cpu_stall); // R5
  AST_STAY_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid && !fill_done |=> !cpu_stall && !fwd_valid); // R5
  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    miss_ready |-> !fill_we && !fill_done); // R10
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> miss_ready); // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !miss_ready); // R2
  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fill_we) && !mem_req && rd_req && rd_word == $past(fill_word) |-> !rd_stall); // R7

endmodule

// File: tb/cwf_line_fill_tb.sv
module cwf_line_fill_tb;
  localparam int WORDS = 16;
  localparam int DW = 32;
  localparam int LW = 8;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wrap = 1'b0, miss_valid = 1'b0, mem_valid = 1'b0, rd_req = 1'b0;
  logic [LW-1:0] miss_line = '0, rd_line = '0;
  logic [IW-1:0] miss_word = '0, rd_word = '0;
  logic [DW-1:0] mem_data = '0;
  logic miss_ready, cpu_stall, fwd_valid, mem_req, fill_we, fill_done, rd_stall;
  logic [DW-1:0] fwd_data, fill_data;
  logic [LW-1:0] mem_req_line;
  logic [IW-1:0] mem_req_word, fill_word;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cwf_line_fill #(.WORDS(WORDS), .DW(DW), .LW(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wrap(mode_wrap), .miss_valid(miss_valid),
    .miss_line(miss_line), .miss_word(miss_word), .miss_ready(miss_ready),
    .cpu_stall(cpu_stall), .fwd_valid(fwd_valid), .fwd_data(fwd_data),
    .mem_req(mem_req), .mem_req_line(mem_req_line), .mem_req_word(mem_req_word),
    .mem_valid(mem_valid), .mem_data(mem_data), .fill_we(fill_we),
    .fill_word(fill_word), .fill_data(fill_data), .fill_done(fill_done),
    .rd_req(rd_req), .rd_line(rd_line), .rd_word(rd_word), .rd_stall(rd_stall));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  localparam int NV = 6;
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 8'h11, 4'd0}, {1'b1, 8'h22, 4'd15}, {1'b1, 8'h33, 4'd7},
    {1'b0, 8'h44, 4'd0}, {1'b0, 8'h55, 4'd15}, {1'b0, 8'h66, 4'd9}};

  task automatic run_fill(logic md, logic [LW-1:0] ln, logic [IW-1:0] cw);
    logic [WORDS-1:0] got = '0;
    logic fwd_seen = 1'b0;
    logic [IW-1:0] eidx;
    @(negedge clk);
    mode_wrap = md; miss_valid = 1'b1; miss_line = ln; miss_word = cw;
    #1;
    chk("R2", "miss_ready at accept", miss_ready, 1);
    chk("R2", "mem_req at accept", mem_req, 1);
    chk("R2", "mem_req_line", mem_req_line, ln);
    if (md) chk("R3", "mem_req_word wrap", mem_req_word, cw);
    else    chk("R4", "mem_req_word natural", mem_req_word, 0);
    @(negedge clk);
    miss_valid = 1'b0;
    #1;
    chk("R2", "miss_ready after accept", miss_ready, 0);
    for (int k = 0; k < WORDS; k++) begin
      eidx = md ? IW'(cw + k) : IW'(k);
      for (int g = $urandom_range(0, 2); g > 0; g--) begin
        @(negedge clk);
        mem_valid = 1'b0; rd_req = 1'b1; rd_line = ln; rd_word = IW'($urandom_range(0, 15));
        #1;
        chk("R7", "rd_stall same line", rd_stall, !got[rd_word]);
        chk("R5", "cpu_stall in gap", cpu_stall, !fwd_seen);
        chk("R6", "fill_we in gap", fill_we, 0);
        rd_line = ln ^ 8'hFF;
        #0.5;
        chk("R7", "rd_stall other line", rd_stall, 0);
      end
      @(negedge clk);
      rd_req = 1'b0;
      mem_valid = 1'b1;
      mem_data = {8'hD0, ln, 12'h0, eidx};
      miss_valid = (k == 5);
      miss_line = ln + 8'd1;
      #1;
      chk("R6", "fill_we on arrival", fill_we, 1);
      chk(md ? "R3" : "R4", "fill_word order", fill_word, eidx);
      chk("R3", "fill_data", fill_data, mem_data);
      chk("R5", "fwd_valid", fwd_valid, eidx == cw);
      if (eidx == cw) chk("R5", "fwd_data", fwd_data, mem_data);
      chk("R5", "cpu_stall on arrival", cpu_stall, !(fwd_seen || eidx == cw));
      chk("R9", "fill_done", fill_done, k == WORDS - 1);
      if (k == 5) begin
        chk("R8", "mem_req while busy", mem_req, 0);
        chk("R8", "miss_ready while busy", miss_ready, 0);
      end
      if (eidx == cw) fwd_seen = 1'b1;
      got[eidx] = 1'b1;
      @(posedge clk);
      #0.5;
      miss_valid = 1'b0;
    end
    @(negedge clk);
    mem_valid = 1'b0; rd_req = 1'b1; rd_line = ln; rd_word = cw;
    #1;
    chk("R9", "miss_ready after done", miss_ready, 1);
    chk("R5", "cpu_stall after done", cpu_stall, 0);
    chk("R7", "rd_stall idle", rd_stall, 0);
    rd_req = 1'b0;
  endtask

  initial begin
    #1;
    chk("R1", "miss_ready in reset", miss_ready, 1);
    chk("R1", "outputs in reset", {cpu_stall, mem_req, fill_we, fwd_valid, fill_done, rd_stall}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1", "miss_ready after reset", miss_ready, 1);
    chk("R1", "outputs after reset", {cpu_stall, mem_req, fill_we, fwd_valid, fill_done, rd_stall}, 0);
    mem_valid = 1'b1; mem_data = 32'hBAD0_0001;
    #1;
    chk("R10", "idle mem_valid writes", {fill_we, fwd_valid, fill_done}, 0);
    @(negedge clk);
    mem_valid = 1'b0;
    for (int v = 0; v < NV; v++) begin
      run_fill(VEC[v][12], VEC[v][11:4], VEC[v][3:0]);
    end
    @(negedge clk);
    mem_valid = 1'b1;
    #1;
    chk("R10", "idle mem_valid after fills", fill_we, 0);
    mem_valid = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule